// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked on-chip requester and an external asynchronous 16-bit static RAM that carries per-byte error correction. It accepts one request at a time over a valid/ready handshake. Each request holds an address, a write flag, a write word and two byte-lane enables. The block turns the request into the active-low select, write-strobe, output-enable and byte-lane strobes that the memory expects. For writes it drives the write word onto the bus through a separate output-enable signal. For reads it captures the read word and the memory's two error status pins on the same clock edge, and returns them with a single-cycle response pulse.

Every analogue timing figure of the memory is a nanosecond parameter. The block converts each one into a whole number of clock cycles by rounding up, with a floor of one cycle. The longest of these figures is the self-initialisation interval after power-up, during which the block refuses all requests. Writes are always performed with the output enable held inactive. A write that follows a read is delayed by a dead interval, so that the memory has stopped driving the bus before the block starts driving it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset is released, `reqReady` stays low and `sramCsN` stays high for INIT_CYC = ceil(T_INIT_NS/CLK_NS) cycles; `reqReady` is first seen high after exactly INIT_CYC rising edges.
- R2: A read holds `sramCsN`=0, `sramOeN`=0 and `sramWeN`=1 with a stable address for RD_CYC = max(ceil(T_AA_NS), ceil(T_RC_NS)) cycles, followed by one capture cycle. The response pulse appears RD_CYC+1 cycles after the accepting edge.
- R3: Read data lane 0 is bits 7:0, selected by `reqBe[0]` and strobed by `sramLbN`; lane 1 is bits 15:8, selected by `reqBe[1]` and strobed by `sramUbN`. Lanes that are not selected return zero in `rspRdata`.
- R4: `rspErrSingle` and `rspErrMulti` are the values of `sramErrSingle` and `sramErrMulti` captured on the same edge as the read data.
- R5: A write takes one setup cycle with the data driven and `sramWeN` high. It then holds `sramWeN` low for exactly PW_CYC = max(ceil(T_PWE_NS), ceil(T_SD_NS)) cycles, with address and data stable, then spends REC_CYC = max(1, RC_CYC-PW_CYC-1) recovery cycles with the data still driven. `reqReady` returns 1+PW_CYC+REC_CYC cycles after acceptance.
- R6: `sramOeN` is high whenever `sramDoutEn` is high, and `sramOeN` and `sramWeN` are never low together.
- R7: A write accepted after a read first spends TURN_CYC = ceil(T_HZ_NS) deselected cycles with the bus released; a write accepted after a write does not.
- R8: A write with both byte enables clear produces no `sramWeN` pulse and leaves the memory contents unchanged.
- R9: A write updates only the byte lanes whose enables are set.
- R10: `reqReady` is high only while the memory is deselected and the bus is released.
- R11: `rspValid` is high for exactly one cycle per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write word |
| reqBe | input | 2 | Byte-lane enables, bit 0 = low byte |
| rspValid | output | 1 | One-cycle read response strobe |
| rspRdata | output | 16 | Read word, unselected lanes zero |
| rspErrSingle | output | 1 | Captured single-error-corrected status |
| rspErrMulti | output | 1 | Captured uncorrectable-error status |
| sramAddr | output | ADDR_W | Memory address |
| sramCsN | output | 1 | Active-low chip select |
| sramWeN | output | 1 | Active-low write strobe |
| sramOeN | output | 1 | Active-low output enable |
| sramUbN | output | 1 | Active-low upper-byte strobe |
| sramLbN | output | 1 | Active-low lower-byte strobe |
| sramDout | output | 16 | Data to the bus |
| sramDoutEn | output | 1 | Drive `sramDout` onto the bus |
| sramDin | input | 16 | Data from the bus |
| sramErrSingle | input | 1 | Memory single-error status pin |
| sramErrMulti | input | 1 | Memory multi-bit-error status pin |

## Verification
The assertions assume that a requester keeps `reqValid` and the request fields steady until the accepting edge, and that the memory only presents read data and status pins while it is being read. The bench drives every request from a task that holds the fields until `reqReady` is seen. It models the memory as an array that returns a poison word until the address has been held in read mode for the access time, and that commits a write only on the rising edge of the write strobe. The bench interleaves reads and writes so that every write-after-read and write-after-write transition occurs, with all four byte-enable codes.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC,
    ST_TURN
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;    // latch the request this cycle
    logic selAct;    // chip selected
    logic readAct;   // output enable asserted
    logic writeAct;  // write strobe window
    logic driveAct;  // write data on the bus
    logic capture;   // sample read data and status
  } seqStrobe_t;

  // nanoseconds to clock cycles, rounded up, at least one
  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int INIT_CYC = 7500,
  parameter int RD_CYC   = 1,
  parameter int PW_CYC   = 1,
  parameter int REC_CYC  = 1,
  parameter int TURN_CYC = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output seqStrobe_t stb
);

  localparam int MAX_A = (INIT_CYC > RD_CYC) ? INIT_CYC : RD_CYC;
  localparam int MAX_B = (PW_CYC > REC_CYC) ? PW_CYC : REC_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_L = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
  localparam int TW    = $clog2(MAX_L + 1);

  seqState_t state, nextState;
  logic [TW-1:0] tmr, loadVal;
  logic lastRead;
  logic tmrDone;

  assign tmrDone = (tmr == '0);

  always_comb begin
    nextState = state;
    loadVal   = '0;
    unique case (state)
      ST_INIT: if (tmrDone) nextState = ST_IDLE;
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqWrite) begin
            nextState = ST_RD_WAIT;
            loadVal   = TW'(RD_CYC - 1);
          end else if (lastRead) begin
            nextState = ST_TURN;
            loadVal   = TW'(TURN_CYC - 1);
          end else begin
            nextState = ST_WR_SETUP;
          end
        end
      end
      ST_RD_WAIT: if (tmrDone) nextState = ST_RD_CAP;
      ST_RD_CAP:  nextState = ST_IDLE;
      ST_TURN:    if (tmrDone) nextState = ST_WR_SETUP;
      ST_WR_SETUP: begin
        nextState = ST_WR_PULSE;
        loadVal   = TW'(PW_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (tmrDone) begin
          nextState = ST_WR_REC;
          loadVal   = TW'(REC_CYC - 1);
        end
      end
      ST_WR_REC: if (tmrDone) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_INIT;
      tmr      <= TW'(INIT_CYC - 1);
      lastRead <= 1'b0;
    end else begin
      state <= nextState;
      if (state != nextState) begin
        tmr <= loadVal;
      end else if (!tmrDone) begin
        tmr <= tmr - TW'(1);
      end
      if (nextState == ST_RD_WAIT && state == ST_IDLE) begin
        lastRead <= 1'b1;
      end else if (nextState == ST_WR_SETUP) begin
        lastRead <= 1'b0;
      end
    end
  end

  always_comb begin
    reqReady     = (state == ST_IDLE);
    stb.accept   = (state == ST_IDLE) && reqValid;
    stb.readAct  = (state == ST_RD_WAIT) || (state == ST_RD_CAP);
    stb.writeAct = (state == ST_WR_PULSE);
    stb.driveAct = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                   (state == ST_WR_REC);
    stb.selAct   = stb.readAct || (state == ST_WR_SETUP) ||
                   (state == ST_WR_PULSE);
    stb.capture  = (state == ST_RD_CAP);
  end

endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramUbN,
  output logic              sramLbN,
  output logic [WORD_W-1:0] sramDout,
  output logic              sramDoutEn,
  input  logic [WORD_W-1:0] sramDin,
  input  logic              sramErrSingle,
  input  logic              sramErrMulti,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspRdata,
  output logic              rspErrSingle,
  output logic              rspErrMulti
);

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;
  logic [LANES-1:0]  beQ;
  logic [WORD_W-1:0] laneMask;
  logic [LANES-1:0]  laneSelN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
    end else if (stb.accept) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      beQ   <= reqBe;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneMask[g*LANE_W +: LANE_W] = {LANE_W{beQ[g]}};
    assign laneSelN[g] = !(stb.selAct && beQ[g]);
  end

  assign sramAddr   = addrQ;
  assign sramCsN    = !stb.selAct;
  assign sramOeN    = !stb.readAct;
  assign sramWeN    = !(stb.writeAct && (|beQ));
  assign sramLbN    = laneSelN[0];
  assign sramUbN    = laneSelN[1];
  assign sramDout   = dataQ;
  assign sramDoutEn = stb.driveAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspRdata     <= '0;
      rspErrSingle <= 1'b0;
      rspErrMulti  <= 1'b0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) begin
        rspRdata     <= sramDin & laneMask;
        rspErrSingle <= sramErrSingle;
        rspErrMulti  <= sramErrMulti;
      end
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int CLK_NS    = 20,
  parameter int T_INIT_NS = 150000,
  parameter int T_AA_NS   = 10,
  parameter int T_RC_NS   = 10,
  parameter int T_PWE_NS  = 8,
  parameter int T_SD_NS   = 6,
  parameter int T_HZ_NS   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqBe,
  output logic              rspValid,
  output logic [15:0]       rspRdata,
  output logic              rspErrSingle,
  output logic              rspErrMulti,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramUbN,
  output logic              sramLbN,
  output logic [15:0]       sramDout,
  output logic              sramDoutEn,
  input  logic [15:0]       sramDin,
  input  logic              sramErrSingle,
  input  logic              sramErrMulti
);

  localparam int INIT_CYC = nsToCycles(T_INIT_NS, CLK_NS);
  localparam int AA_CYC   = nsToCycles(T_AA_NS, CLK_NS);
  localparam int RC_CYC   = nsToCycles(T_RC_NS, CLK_NS);
  localparam int PWE_CYC  = nsToCycles(T_PWE_NS, CLK_NS);
  localparam int SD_CYC   = nsToCycles(T_SD_NS, CLK_NS);
  localparam int TURN_CYC = nsToCycles(T_HZ_NS, CLK_NS);
  localparam int RD_CYC   = (AA_CYC > RC_CYC) ? AA_CYC : RC_CYC;
  localparam int PW_CYC   = (PWE_CYC > SD_CYC) ? PWE_CYC : SD_CYC;
  localparam int REC_CYC  = (RC_CYC > PW_CYC + 1) ? (RC_CYC - PW_CYC - 1) : 1;

  seqStrobe_t stb;

  sram_seq_fsm #(
    .INIT_CYC (INIT_CYC),
    .RD_CYC   (RD_CYC),
    .PW_CYC   (PW_CYC),
    .REC_CYC  (REC_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .stb      (stb)
  );

  sram_seq_dp #(
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .reqAddr       (reqAddr),
    .reqWdata      (reqWdata),
    .reqBe         (reqBe),
    .sramAddr      (sramAddr),
    .sramCsN       (sramCsN),
    .sramWeN       (sramWeN),
    .sramOeN       (sramOeN),
    .sramUbN       (sramUbN),
    .sramLbN       (sramLbN),
    .sramDout      (sramDout),
    .sramDoutEn    (sramDoutEn),
    .sramDin       (sramDin),
    .sramErrSingle (sramErrSingle),
    .sramErrMulti  (sramErrMulti),
    .rspValid      (rspValid),
    .rspRdata      (rspRdata),
    .rspErrSingle  (rspErrSingle),
    .rspErrMulti   (rspErrMulti)
  );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int ADDR_W    = 19,
  parameter int CLK_NS    = 20,
  parameter int T_INIT_NS = 150000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              sramCsN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramUbN,
  input logic              sramLbN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [15:0]       sramDout,
  input logic              sramDoutEn
);

  localparam int INIT_CYC = sram_seq_pkg::nsToCycles(T_INIT_NS, CLK_NS);
  localparam int CW       = $clog2(INIT_CYC + 1);

  logic [CW-1:0] initCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initCnt <= '0;
    else if (initCnt != CW'(INIT_CYC)) initCnt <= initCnt + CW'(1);
  end

  a_r1_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (initCnt < CW'(INIT_CYC)) |-> (!reqReady && sramCsN));

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCsN && $past(!sramCsN)) |-> $stable(sramAddr));

  a_r5_dout_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN && $past(!sramWeN)) |-> $stable(sramDout));

  a_r5_drive_before_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> $past(sramDoutEn));

  a_r6_oe_off_while_driving: assert property (@(posedge clk) disable iff (!rstN)
    sramDoutEn |-> sramOeN);

  a_r6_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramOeN);

  a_r8_strobe_needs_lane: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCsN && !(sramUbN && sramLbN)));

  a_r10_ready_deselected: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCsN && !sramDoutEn));

  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .CLK_NS    (CLK_NS),
  .T_INIT_NS (T_INIT_NS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .rspValid   (rspValid),
  .sramCsN    (sramCsN),
  .sramWeN    (sramWeN),
  .sramOeN    (sramOeN),
  .sramUbN    (sramUbN),
  .sramLbN    (sramLbN),
  .sramAddr   (sramAddr),
  .sramDout   (sramDout),
  .sramDoutEn (sramDoutEn)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;

  localparam int ADDR_W  = 5;
  localparam int WORDS   = 1 << ADDR_W;
  localparam int CLK_NS  = 20;
  localparam int INIT_NS = 2000;
  localparam int AA_NS   = 50;
  localparam int RC_NS   = 90;
  localparam int PWE_NS  = 30;
  localparam int SD_NS   = 25;
  localparam int HZ_NS   = 30;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int INIT_CYC = cyc(INIT_NS);
  localparam int AA_CYC   = cyc(AA_NS);
  localparam int RD_CYC   = (cyc(AA_NS) > cyc(RC_NS)) ? cyc(AA_NS) : cyc(RC_NS);
  localparam int PW_CYC   = (cyc(PWE_NS) > cyc(SD_NS)) ? cyc(PWE_NS) : cyc(SD_NS);
  localparam int REC_CYC  = (cyc(RC_NS) > PW_CYC + 1) ? cyc(RC_NS) - PW_CYC - 1 : 1;
  localparam int TURN_CYC = cyc(HZ_NS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0] reqBe = '0;
  logic reqReady, rspValid, rspErrSingle, rspErrMulti;
  logic [15:0] rspRdata;
  logic [ADDR_W-1:0] sramAddr;
  logic sramCsN, sramWeN, sramOeN, sramUbN, sramLbN, sramDoutEn;
  logic [15:0] sramDout, sramDin;
  logic sramErrSingle, sramErrMulti;

  always #(CLK_NS/2) clk = ~clk;

  sram_seq_ctrl #(
    .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_INIT_NS(INIT_NS), .T_AA_NS(AA_NS),
    .T_RC_NS(RC_NS), .T_PWE_NS(PWE_NS), .T_SD_NS(SD_NS), .T_HZ_NS(HZ_NS)
  ) u_sram_seq_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErrSingle(rspErrSingle),
    .rspErrMulti(rspErrMulti), .sramAddr(sramAddr), .sramCsN(sramCsN),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramUbN(sramUbN), .sramLbN(sramLbN),
    .sramDout(sramDout), .sramDoutEn(sramDoutEn), .sramDin(sramDin),
    .sramErrSingle(sramErrSingle), .sramErrMulti(sramErrMulti)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [WORDS];
  int rdAge = 0;
  logic prevRead = 1'b0;
  logic [ADDR_W-1:0] lastAddr = '0;
  int sinceRd = 1000;
  int pulseCnt = 0;
  logic [ADDR_W-1:0] pAddr;
  logic [15:0] pData;
  logic pUb, pLb;
  int r5Viol = 0, r6Viol = 0, r7Viol = 0;

  logic readMode, readValid, f1, f2;
  assign readMode  = !sramCsN && !sramOeN && sramWeN;
  assign readValid = readMode && (rdAge >= AA_CYC);
  assign f1 = sramAddr[0];
  assign f2 = sramAddr[1] ^ sramAddr[3];
  assign sramDin = readValid ? {sramUbN ? 8'hA5 : mem[sramAddr][15:8],
                                sramLbN ? 8'hA5 : mem[sramAddr][7:0]} : 16'hDEAD;
  assign sramErrSingle = readValid ? f1 : !f1;
  assign sramErrMulti  = readValid ? f2 : !f2;

  initial for (int i = 0; i < WORDS; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (rstN) begin
      if (sramDoutEn && readMode) r6Viol++;
      if (!sramWeN && !sramOeN) r6Viol++;
      if (sramDoutEn && sinceRd < TURN_CYC) r7Viol++;
      sinceRd = readMode ? 0 : ((sinceRd < 1000) ? sinceRd + 1 : sinceRd);
      if (!sramCsN && !sramWeN) begin
        if (pulseCnt == 0) begin
          pAddr = sramAddr; pData = sramDout; pUb = !sramUbN; pLb = !sramLbN;
          if (!sramDoutEn) r5Viol++;
        end else if (sramDout != pData || sramAddr != pAddr) begin
          r5Viol++;
        end
        pulseCnt++;
      end else if (pulseCnt > 0) begin
        chk(pulseCnt == PW_CYC, "R5 write strobe width", pulseCnt, PW_CYC);
        if (pUb) mem[pAddr][15:8] <= pData[15:8];
        if (pLb) mem[pAddr][7:0]  <= pData[7:0];
        pulseCnt = 0;
      end
      rdAge    <= readMode ? ((prevRead && sramAddr == lastAddr) ? rdAge + 1 : 1) : 0;
      prevRead <= readMode;
      lastAddr <= sramAddr;
    end
  end

  // ---------------- request driver ----------------
  logic [15:0] shadow [WORDS];

  task automatic doReq(input bit wr, input int a, input logic [15:0] d,
                       input logic [1:0] be, output int n,
                       output logic [15:0] rd, output logic e1, output logic e2);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(a); reqWdata = d; reqBe = be;
    while (!reqReady) @(negedge clk);
    chk(sramCsN && !sramDoutEn, "R10 ready only while deselected", {sramCsN, sramDoutEn}, 2);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0; rd = '0; e1 = 1'b0; e2 = 1'b0;
    if (wr) begin
      while (!reqReady && n < 1000) begin
        chk(!rspValid, "R11 no response for write", rspValid, 0);
        @(negedge clk); n++;
      end
    end else begin
      while (!rspValid && n < 1000) begin @(negedge clk); n++; end
      rd = rspRdata; e1 = rspErrSingle; e2 = rspErrMulti;
      @(negedge clk);
      chk(!rspValid, "R11 response lasts one cycle", rspValid, 0);
    end
  endtask

  function automatic logic [15:0] patA(input int a);
    return 16'(a * 16'h0931) ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] patB(input int a);
    return 16'(a * 16'h1D07 + 16'h00F1);
  endfunction

  task automatic readCheck(input int a, input logic [1:0] be, input string tag);
    int n; logic [15:0] rd; logic e1, e2; logic [15:0] exp;
    doReq(1'b0, a, 16'h0, be, n, rd, e1, e2);
    exp = {be[1] ? shadow[a][15:8] : 8'h00, be[0] ? shadow[a][7:0] : 8'h00};
    chk(n == RD_CYC + 1, "R2 read latency", n, RD_CYC + 1);
    chk(rd == exp, tag, rd, exp);
    chk(e1 == a[0] && e2 == (a[1] ^ a[3]), "R4 status flags", {e1, e2}, {a[0], a[1] ^ a[3]});
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n; logic [15:0] rd; logic e1, e2; bit bad;
    for (int i = 0; i < WORDS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk(sramCsN && !reqReady && !sramDoutEn && !rspValid, "R1 reset state",
        {sramCsN, reqReady, sramDoutEn, rspValid}, 4'b1000);
    rstN = 1'b1;
    n = 0; bad = 0;
    while (!reqReady && n < 1000) begin
      @(negedge clk); n++;
      if (!reqReady && !sramCsN) bad = 1;
    end
    chk(n == INIT_CYC, "R1 power-up hold-off length", n, INIT_CYC);
    chk(!bad, "R1 deselected during hold-off", bad, 0);

    // full-word writes, each after a write (first after reset)
    for (int a = 0; a < WORDS; a++) begin
      doReq(1'b1, a, patA(a), 2'b11, n, rd, e1, e2);
      shadow[a] = patA(a);
      chk(n == 1 + PW_CYC + REC_CYC, "R7 R5 write-after-write latency", n, 1 + PW_CYC + REC_CYC);
    end
    for (int a = 0; a < WORDS; a++) readCheck(a, 2'b11, "R3 full-word read");

    // read then partial write: turnaround, lane masking
    for (int a = 0; a < WORDS; a++) begin
      logic [1:0] rbe;
      logic [1:0] wbe;
      rbe = 2'(a % 3 + 1);
      readCheck(a, rbe, "R3 lane-masked read");
      wbe = 2'(a % 4);
      doReq(1'b1, a, patB(a), wbe, n, rd, e1, e2);
      chk(n == TURN_CYC + 1 + PW_CYC + REC_CYC, "R7 write-after-read latency",
          n, TURN_CYC + 1 + PW_CYC + REC_CYC);
      if (wbe[1]) shadow[a][15:8] = patB(a)[15:8];
      if (wbe[0]) shadow[a][7:0]  = patB(a)[7:0];
    end
    for (int a = 0; a < WORDS; a++)
      readCheck(a, 2'b11, (a % 4 == 0) ? "R8 empty-enable write left word" : "R9 byte-lane write");

    repeat (4) @(negedge clk);
    chk(r5Viol == 0, "R5 data driven and stable under strobe", r5Viol, 0);
    chk(r6Viol == 0, "R6 no bus contention", r6Viol, 0);
    chk(r7Viol == 0, "R7 bus released before write drive", r7Viol, 0);
    summary();
    $finish;
  end

endmodule